// File: doc/BRIEF.md
# Trigger Source Selector and Encoder

This block gathers the trigger lines of an acquisition front end and decides which one fired. It takes five differential-class lines, five single-ended lines, a fast reference trigger, an internal self-trigger and a software trigger bit. It also forms three two-input coincidences from these. Together they make a 16-entry source vector. A 16-bit enable word masks that vector. Each source is edge-detected, so an input that rises and then stays high yields exactly one strobe.

On a strobe, the block reports a 4-bit trigger code. The code counts down from 0xF as the source index goes up. When several enabled sources rise in the same cycle, the lowest-numbered one sets the code. A 5-bit override field can force the code: when its top bit is set, the lower four bits replace the encoded value. The code register loads only when a strobe is issued and holds its value between strobes.

The input lines are registered once before edge detection, and the strobe and code are registered once after it. An input change that lands before a clock edge therefore appears on the outputs after the second edge.

Top module: `trig_src_encoder`

## Requirements
- R1: After reset, the strobe output is 0 and the code output is 0x0.
- R2: Enable bits 0 to 4 gate differential lines 0 to 4, and bits 5 to 9 gate single-ended lines 0 to 4. Source index k gives code 15-k, so differential line 0 gives 0xF and single-ended line 4 gives 0x6.
- R3: Enable bit 10 gates the fast reference trigger (code 0x5), bit 11 the self-trigger (code 0x4) and bit 13 the software trigger bit (code 0x2). The software trigger fires on a rising edge of its bit.
- R4: Enable bit 12 gates the AND of differential lines 0 and 1 (code 0x3). Bit 14 gates the AND of single-ended lines 0 and 1 (code 0x1), and bit 15 the AND of single-ended lines 2 and 3 (code 0x0).
- R5: A source whose enable bit is 0 produces no strobe and leaves the code unchanged.
- R6: A 0-to-1 transition of an enabled source produces a strobe of exactly one cycle, two clock edges after the input changes, even if the input then stays high.
- R7: When several enabled sources rise in the same cycle, only one strobe is issued, and the code is that of the lowest-numbered source.
- R8: When override bit 4 is 1 at the time of a strobe, the code equals override bits 3..0. When bit 4 is 0, bits 3..0 have no effect.
- R9: The code output keeps its value in every cycle without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| diff_i | input | 5 | Differential-class trigger lines |
| se_i | input | 5 | Single-ended trigger lines |
| fast_ref_i | input | 1 | Fast reference trigger |
| self_trig_i | input | 1 | Internal self-trigger |
| sw_trig_i | input | 1 | Software trigger register bit |
| en_i | input | 16 | Per-source enable word |
| ovr_i | input | 5 | Override: bit 4 forces the code, bits 3..0 give its value |
| trig_stb_o | output | 1 | One-cycle trigger strobe |
| trig_code_o | output | 4 | Trigger code, loaded with each strobe |

## Verification
Two things can land in the same cycle: several enabled sources rising at once, and a plain line rising together with a coincidence built from it. Both force the priority choice. The bench provokes them by raising random sets of lines under random enable words, including a coincidence pair whose own line is also enabled. It judges the result against a source vector and a lowest-set-bit search computed in the bench. It also checks that only one strobe appears and that the strobe does not repeat on the next cycle. The override field is swept across all 32 values against the same stimulus, to show that the force bit wins over the priority result.

// File: rtl/trig_sel_pkg.sv
package trig_sel_pkg;
   localparam int unsigned TRIG_CODE_W = 4;
   localparam int unsigned TRIG_FIXED_SRC = 6;
   typedef logic [TRIG_CODE_W-1:0] trig_code_t;
endpackage

// File: rtl/trig_src_map.sv
module trig_src_map #(
   parameter int unsigned N_DIFF = 5,
   parameter int unsigned N_SE   = 5,
   localparam int unsigned NS    = N_DIFF + N_SE + trig_sel_pkg::TRIG_FIXED_SRC
) (
   input  logic [N_DIFF-1:0] diff_i,
   input  logic [N_SE-1:0]   se_i,
   input  logic              fast_ref_i,
   input  logic              self_trig_i,
   input  logic              sw_trig_i,
   output logic [NS-1:0]     src_o
);
   localparam int unsigned OFS_SE    = N_DIFF;
   localparam int unsigned OFS_FIXED = N_DIFF + N_SE;

   for (genvar d = 0; d < N_DIFF; d++) begin : g_diff
      assign src_o[d] = diff_i[d];
   end
   for (genvar s = 0; s < N_SE; s++) begin : g_se
      assign src_o[OFS_SE+s] = se_i[s];
   end

   // fixed slots: fast ref, self, diff pair, software, se pair 0/1, se pair 2/3
   assign src_o[OFS_FIXED+0] = fast_ref_i;
   assign src_o[OFS_FIXED+1] = self_trig_i;
   assign src_o[OFS_FIXED+2] = diff_i[0] & diff_i[1];
   assign src_o[OFS_FIXED+3] = sw_trig_i;
   assign src_o[OFS_FIXED+4] = se_i[0] & se_i[1];
   assign src_o[OFS_FIXED+5] = se_i[2] & se_i[3];
endmodule

// File: rtl/trig_edge_det.sv
module trig_edge_det #(
   parameter int unsigned W      = 16,
   parameter bit          REG_IN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl_i,
   output logic [W-1:0] rise_o
);
   logic [W-1:0] cur;
   logic [W-1:0] prev_q;

   if (REG_IN) begin : g_reg_in
      logic [W-1:0] cur_q;
      always_ff @(posedge clk) begin
         if (!rst_n) cur_q <= '0;
         else        cur_q <= lvl_i;
      end
      assign cur = cur_q;
   end else begin : g_raw_in
      assign cur = lvl_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= cur;
   end

   assign rise_o = cur & ~prev_q;

   // R6: a source cannot report a rising edge on two cycles in a row
   p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/trig_prio_enc.sv
module trig_prio_enc #(
   parameter int unsigned W      = 16,
   parameter int unsigned CODE_W = 4,
   localparam int unsigned IDX_W = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]      req_i,
   output logic              hit_o,
   output logic [IDX_W-1:0]  idx_o,
   output logic [CODE_W-1:0] code_o
);
   localparam logic [CODE_W-1:0] TOP_CODE = {CODE_W{1'b1}};

   always_comb begin
      hit_o = 1'b0;
      idx_o = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            hit_o = 1'b1;
            idx_o = IDX_W'(i);
         end
      end
   end

   assign code_o = TOP_CODE - CODE_W'(idx_o);
endmodule

// File: rtl/trig_src_encoder.sv
module trig_src_encoder
   import trig_sel_pkg::*;
#(
   parameter int unsigned N_DIFF = 5,
   parameter int unsigned N_SE   = 5,
   parameter bit          REG_IN = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [N_DIFF-1:0]          diff_i,
   input  logic [N_SE-1:0]            se_i,
   input  logic                       fast_ref_i,
   input  logic                       self_trig_i,
   input  logic                       sw_trig_i,
   input  logic [N_DIFF+N_SE+5:0]     en_i,
   input  logic [TRIG_CODE_W:0]       ovr_i,
   output logic                       trig_stb_o,
   output logic [TRIG_CODE_W-1:0]     trig_code_o
);
   localparam int unsigned NS    = N_DIFF + N_SE + TRIG_FIXED_SRC;
   localparam int unsigned IDX_W = $clog2(NS);

   if (N_DIFF < 2) begin : g_bad_diff
      $error("trig_src_encoder: N_DIFF must be at least 2");
   end
   if (N_SE < 4) begin : g_bad_se
      $error("trig_src_encoder: N_SE must be at least 4");
   end
   if (NS > (1 << TRIG_CODE_W)) begin : g_bad_ns
      $error("trig_src_encoder: more sources than codes");
   end

   logic [NS-1:0]    src;
   logic [NS-1:0]    rise;
   logic [NS-1:0]    rise_en;
   logic             hit;
   logic [IDX_W-1:0] idx;
   trig_code_t       enc_code;
   logic             stb_q;
   trig_code_t       code_q;

   trig_src_map #(.N_DIFF(N_DIFF), .N_SE(N_SE)) u_map (
      .diff_i(diff_i), .se_i(se_i), .fast_ref_i(fast_ref_i),
      .self_trig_i(self_trig_i), .sw_trig_i(sw_trig_i), .src_o(src)
   );

   trig_edge_det #(.W(NS), .REG_IN(REG_IN)) u_edge (
      .clk(clk), .rst_n(rst_n), .lvl_i(src), .rise_o(rise)
   );

   assign rise_en = rise & en_i;

   trig_prio_enc #(.W(NS), .CODE_W(TRIG_CODE_W)) u_enc (
      .req_i(rise_en), .hit_o(hit), .idx_o(idx), .code_o(enc_code)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stb_q  <= 1'b0;
         code_q <= '0;
      end else begin
         stb_q <= hit;
         if (hit) code_q <= ovr_i[TRIG_CODE_W] ? ovr_i[TRIG_CODE_W-1:0] : enc_code;
      end
   end

   assign trig_stb_o  = stb_q;
   assign trig_code_o = code_q;

   // R5: a strobe needs an enabled rising source in the cycle before
   p_strobe_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      trig_stb_o |-> $past(|rise_en));
   // R6: an encoder hit becomes a strobe on the next edge
   p_strobe_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> trig_stb_o);
   // R7: the chosen source is requesting and no lower source is
   p_lowest_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (rise_en[idx] && ((rise_en & ((NS'(1) << idx) - NS'(1))) == '0)));
   // R8: a forced code is taken from the override field
   p_override_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && ovr_i[TRIG_CODE_W]) |=> (trig_code_o == $past(ovr_i[TRIG_CODE_W-1:0])));
   // R9: without a hit the code output does not move
   p_code_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> $stable(trig_code_o));
endmodule

// File: tb/trig_src_encoder_test.sv
module trig_src_encoder_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  diff = '0, se = '0;
   logic        fast = 1'b0, selft = 1'b0, sw = 1'b0;
   logic [15:0] en = '0;
   logic [4:0]  ovr = '0;
   logic        stb;
   logic [3:0]  code;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   logic [3:0] exp_code = 4'h0;
   logic [31:0] rng = 32'h1234_5678;

   always #(CLK_PERIOD/2) clk = ~clk;

   trig_src_encoder uut (
      .clk(clk), .rst_n(rst_n), .diff_i(diff), .se_i(se), .fast_ref_i(fast),
      .self_trig_i(selft), .sw_trig_i(sw), .en_i(en), .ovr_i(ovr),
      .trig_stb_o(stb), .trig_code_o(code)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] model_src(input logic [4:0] d, input logic [4:0] s,
                                             input logic f, input logic sf, input logic w);
      logic [15:0] v;
      v[4:0]  = d;
      v[9:5]  = s;
      v[10]   = f;
      v[11]   = sf;
      v[12]   = d[0] & d[1];
      v[13]   = w;
      v[14]   = s[0] & s[1];
      v[15]   = s[2] & s[3];
      return v;
   endfunction

   function automatic logic [31:0] next_rng(input logic [31:0] x);
      logic [31:0] y;
      y = x ^ (x << 13);
      y = y ^ (y >> 17);
      y = y ^ (y << 5);
      return y;
   endfunction

   // raise the lines from all-low, check strobe and code, then release
   task automatic fire(input logic [4:0] d, input logic [4:0] s, input logic f,
                       input logic sf, input logic w, input logic [15:0] e,
                       input logic [4:0] ov, input string req);
      logic [15:0] hitv;
      int exp_hit;
      hitv = model_src(d, s, f, sf, w) & e;
      exp_hit = (hitv != 0) ? 1 : 0;
      if (exp_hit == 1) begin
         if (ov[4]) exp_code = ov[3:0];
         else begin
            for (int i = 15; i >= 0; i--) if (hitv[i]) exp_code = 4'(15 - i);
         end
      end
      @(negedge clk);
      diff = d; se = s; fast = f; selft = sf; sw = w; en = e; ovr = ov;
      @(posedge clk); @(posedge clk); @(negedge clk);
      check({req, " strobe"}, int'(stb), exp_hit);
      check({req, " code"}, int'(code), int'(exp_code));
      @(posedge clk); @(negedge clk);
      check("R6 held input no second strobe", int'(stb), 0);
      diff = '0; se = '0; fast = 1'b0; selft = 1'b0; sw = 1'b0;
      @(posedge clk); @(posedge clk); @(negedge clk);
      check("R9 no strobe on release", int'(stb), 0);
      check("R9 code held", int'(code), int'(exp_code));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [4:0] d, s;
      logic f, sf, w;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 reset strobe", int'(stb), 0);
      check("R1 reset code", int'(code), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // each source alone, enabled alone (R2, R3, R4), then masked off (R5)
      for (int i = 0; i < 16; i++) begin
         d = '0; s = '0; f = 0; sf = 0; w = 0;
         if (i < 5) d[i] = 1'b1;
         else if (i < 10) s[i-5] = 1'b1;
         else if (i == 10) f = 1'b1;
         else if (i == 11) sf = 1'b1;
         else if (i == 12) d = 5'b00011;
         else if (i == 13) w = 1'b1;
         else if (i == 14) s = 5'b00011;
         else s = 5'b01100;
         if (i < 10) fire(d, s, f, sf, w, 16'(1 << i), 5'h00, "R2 single line");
         else if (i == 12 || i >= 14) fire(d, s, f, sf, w, 16'(1 << i), 5'h00, "R4 coincidence");
         else fire(d, s, f, sf, w, 16'(1 << i), 5'h00, "R3 ref/self/sw");
         fire(d, s, f, sf, w, ~16'(1 << i), 5'h00, "R5 masked source");
      end
      fire(5'h1f, 5'h1f, 1, 1, 1, 16'h0000, 5'h00, "R5 all disabled");

      // random line sets against random enables (R7)
      for (int n = 0; n < 60; n++) begin
         rng = next_rng(rng);
         fire(rng[4:0], rng[9:5], rng[10], rng[11], rng[12], rng[31:16],
              5'h00, "R7 priority");
      end
      fire(5'b00011, 5'h00, 0, 0, 0, 16'h1002, 5'h00, "R7 coincidence vs line");

      // override sweep (R8)
      for (int v = 0; v < 32; v++)
         fire(5'h00, 5'b00100, 0, 0, 0, 16'hffff, 5'(v), "R8 override");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule